// File: doc/BRIEF.md
# Serial Line Routing Switch With Mode Button

This block connects the transmit and receive lines of three serial endpoints: a local controller, a satellite timing receiver and a host PC. The connections are set by one of four routing modes. A single front-panel pushbutton steps through the modes in a fixed ring, and a one-hot LED vector shows which mode is active. The block only switches wires. It does no baud-rate generation and no framing, and the transmit-to-receive paths are purely combinational.

Three modes form two-way links, one pair of endpoints per mode. The fourth mode, auto, makes two one-way links at once. The receiver's data goes to the controller, and the controller's data goes to the PC. Because nothing reaches the controller from the PC in auto, the PC cannot send commands in this mode. When the switch enters the receiver-to-PC mode, it keeps every line idle for a programmable delay (five seconds by default) before it joins the two endpoints. This lets a user step past that mode without a burst of receiver traffic reaching the PC. Any receive line that has no source in the current state is held high (idle).

Top module: `uart_route_switch`

## Requirements
- R1: After reset the mode is controller-PC, `mode_led_o` = 4'b0001 and `hold_led_o` = 0. Bit i of `mode_led_o` is high only in mode i, with mode codes 0 = controller-PC, 1 = receiver-PC, 2 = controller-receiver, 3 = auto. Exactly one bit is high at all times.
- R2: In mode 0, `ctl_rx_o` follows `pc_tx_i`, `pc_rx_o` follows `ctl_tx_i` and `gps_rx_o` is 1.
- R3: In mode 1, once the hold has expired, `pc_rx_o` follows `gps_tx_i`, `gps_rx_o` follows `pc_tx_i` and `ctl_rx_o` is 1.
- R4: In mode 2, `ctl_rx_o` follows `gps_tx_i`, `gps_rx_o` follows `ctl_tx_i` and `pc_rx_o` is 1.
- R5: In mode 3, `ctl_rx_o` follows `gps_tx_i`, `pc_rx_o` follows `ctl_tx_i` and `gps_rx_o` is 1. `pc_tx_i` has no effect on any output.
- R6: Each accepted press moves the mode one step along 0, 1, 2, 3, 0. Keeping the button held, or releasing it, never causes a further step.
- R7: The button is synchronized and debounced. A level that lasts fewer than `CLK_FREQ_HZ/1000*DEBOUNCE_MS` clock cycles is ignored. An accepted press changes the mode within that count plus 4 cycles.
- R8: Each entry into mode 1 raises `hold_led_o` for exactly `CLK_FREQ_HZ/1000*LINK_DELAY_MS` cycles. During that time all three receive lines are 1.
- R9: A press during the hold cancels it. A later entry into mode 1 starts the full hold again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 1 | Raw pushbutton, high when pressed |
| ctl_tx_i | input | 1 | Controller transmit line |
| gps_tx_i | input | 1 | Timing receiver transmit line |
| pc_tx_i | input | 1 | Host PC transmit line |
| ctl_rx_o | output | 1 | Controller receive line |
| gps_rx_o | output | 1 | Timing receiver receive line |
| pc_rx_o | output | 1 | Host PC receive line |
| mode_led_o | output | 4 | One-hot mode indicator |
| hold_led_o | output | 1 | High while the receiver-PC link is held off |

## Verification
The bench builds the block with `CLK_FREQ_HZ` = 10000, `DEBOUNCE_MS` = 1 and `LINK_DELAY_MS` = 5. This gives a 10-cycle debounce and a 50-cycle hold. With these values a complete trip round the mode ring, short glitches, a long held press, a press that lands mid-hold and a cycle-exact measurement of the hold all fit in a few hundred cycles. Random transmit traffic on all three lines exposes any misrouted or leaking path in every state.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;
  typedef enum logic [1:0] {
    RT_CTL_PC  = 2'd0,
    RT_GPS_PC  = 2'd1,
    RT_CTL_GPS = 2'd2,
    RT_AUTO    = 2'd3
  } route_mode_e;

  localparam int unsigned NUM_MODES = 4;
endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int unsigned DB_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic press_o
);
  localparam int unsigned CW = (DB_CYC < 2) ? 1 : $clog2(DB_CYC);

  logic [1:0]    sync_q;
  logic          level_q;
  logic [CW-1:0] run_q;
  logic          press_q;
  logic          synced;
  logic          settle;

  assign synced = sync_q[1];
  assign settle = (synced != level_q) && (run_q == CW'(DB_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      level_q <= 1'b0;
      run_q   <= '0;
      press_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], btn_i};
      press_q <= settle && synced;
      if (synced == level_q) begin
        run_q <= '0;
      end else if (settle) begin
        level_q <= synced;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign press_o = press_q;
endmodule

// File: rtl/mode_sequencer.sv
module mode_sequencer
  import uart_route_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 50
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        press_i,
  output route_mode_e mode_o,
  output logic        hold_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  route_mode_e   mode_q;
  route_mode_e   mode_nxt;
  logic [HW-1:0] hold_q;

  assign mode_nxt = route_mode_e'(mode_q + 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RT_CTL_PC;
      hold_q <= '0;
    end else if (press_i) begin
      mode_q <= mode_nxt;
      // entering the receiver-PC mode (re)arms the hold; any other step cancels it
      hold_q <= (mode_nxt == RT_GPS_PC) ? HW'(HOLD_CYC) : '0;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign hold_o = (hold_q != '0);
endmodule

// File: rtl/route_crossbar.sv
module route_crossbar
  import uart_route_pkg::*;
(
  input  route_mode_e mode_i,
  input  logic        hold_i,
  input  logic        ctl_tx_i,
  input  logic        gps_tx_i,
  input  logic        pc_tx_i,
  output logic        ctl_rx_o,
  output logic        gps_rx_o,
  output logic        pc_rx_o
);
  always_comb begin
    ctl_rx_o = 1'b1;
    gps_rx_o = 1'b1;
    pc_rx_o  = 1'b1;
    unique case (mode_i)
      RT_CTL_PC: begin
        ctl_rx_o = pc_tx_i;
        pc_rx_o  = ctl_tx_i;
      end
      RT_GPS_PC: begin
        if (!hold_i) begin
          pc_rx_o  = gps_tx_i;
          gps_rx_o = pc_tx_i;
        end
      end
      RT_CTL_GPS: begin
        ctl_rx_o = gps_tx_i;
        gps_rx_o = ctl_tx_i;
      end
      RT_AUTO: begin
        ctl_rx_o = gps_tx_i;
        pc_rx_o  = ctl_tx_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uart_route_switch.sv
module uart_route_switch
  import uart_route_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ   = 50_000_000,
  parameter int unsigned DEBOUNCE_MS   = 10,
  parameter int unsigned LINK_DELAY_MS = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       btn_i,
  input  logic       ctl_tx_i,
  input  logic       gps_tx_i,
  input  logic       pc_tx_i,
  output logic       ctl_rx_o,
  output logic       gps_rx_o,
  output logic       pc_rx_o,
  output logic [3:0] mode_led_o,
  output logic       hold_led_o
);
  localparam int unsigned CYC_PER_MS = CLK_FREQ_HZ / 1000;
  localparam int unsigned DB_CYC     = CYC_PER_MS * DEBOUNCE_MS;
  localparam int unsigned HOLD_CYC   = CYC_PER_MS * LINK_DELAY_MS;

  logic        press;
  logic        hold;
  route_mode_e mode;

  btn_conditioner #(.DB_CYC(DB_CYC)) u_btn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (btn_i),
    .press_o(press)
  );

  mode_sequencer #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .press_i(press),
    .mode_o (mode),
    .hold_o (hold)
  );

  route_crossbar u_xbar (
    .mode_i  (mode),
    .hold_i  (hold),
    .ctl_tx_i(ctl_tx_i),
    .gps_tx_i(gps_tx_i),
    .pc_tx_i (pc_tx_i),
    .ctl_rx_o(ctl_rx_o),
    .gps_rx_o(gps_rx_o),
    .pc_rx_o (pc_rx_o)
  );

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_led
    assign mode_led_o[i] = (mode == route_mode_e'(i));
  end

  assign hold_led_o = hold;
endmodule

// File: rtl/uart_route_switch_chk.sv
module uart_route_switch_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctl_tx_i,
  input logic       gps_tx_i,
  input logic       pc_tx_i,
  input logic       ctl_rx_o,
  input logic       gps_rx_o,
  input logic       pc_rx_o,
  input logic [3:0] mode_led_o,
  input logic       hold_led_o
);
  // R1
  led_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_led_o) == 1);

  // R2
  ctl_pc_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_led_o[0] |-> (ctl_rx_o == pc_tx_i) && (pc_rx_o == ctl_tx_i) && gps_rx_o);

  // R5
  auto_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_led_o[3] |-> (ctl_rx_o == gps_tx_i) && (pc_rx_o == ctl_tx_i) && gps_rx_o);

  // R6
  mode_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_led_o) |-> mode_led_o == {$past(mode_led_o[2:0]), $past(mode_led_o[3])});

  // R8
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_led_o |-> ctl_rx_o && gps_rx_o && pc_rx_o);

  // R8
  hold_on_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_led_o[1]) |-> hold_led_o);

  // R9
  hold_only_gps_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_led_o |-> mode_led_o[1]);
endmodule

bind uart_route_switch uart_route_switch_chk u_chk (.*);

// File: tb/sim_uart_route_switch.sv
`timescale 1ns/1ps
module sim_uart_route_switch;
  localparam int unsigned F_HZ = 10000;
  localparam int unsigned DB_MS = 1;
  localparam int unsigned DL_MS = 5;
  localparam int DB  = F_HZ / 1000 * DB_MS;
  localparam int DLY = F_HZ / 1000 * DL_MS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn = 1'b0;
  logic ctl_tx = 1'b1, gps_tx = 1'b1, pc_tx = 1'b1;
  logic ctl_rx, gps_rx, pc_rx, hold_led;
  logic [3:0] mode_led;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  uart_route_switch #(
    .CLK_FREQ_HZ(F_HZ), .DEBOUNCE_MS(DB_MS), .LINK_DELAY_MS(DL_MS)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .btn_i(btn),
    .ctl_tx_i(ctl_tx), .gps_tx_i(gps_tx), .pc_tx_i(pc_tx),
    .ctl_rx_o(ctl_rx), .gps_rx_o(gps_rx), .pc_rx_o(pc_rx),
    .mode_led_o(mode_led), .hold_led_o(hold_led)
  );

  always #5 clk = ~clk;

  // behavioural reference: button history, accepted level, mode ring, hold cycles left
  bit  hist[$];
  bit  m_level;
  int  m_run;
  bit  m_press;
  int  m_mode;
  int  m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {1'b0, 1'b0};
      m_level = 0; m_run = 0; m_press = 0; m_mode = 0; m_hold = 0;
    end else begin
      bit seen;
      bit fresh;
      seen = hist[0];
      fresh = 0;
      if (seen == m_level) m_run = 0;
      else if (m_run == DB - 1) begin
        m_level = seen; m_run = 0; fresh = seen;
      end else m_run = m_run + 1;
      if (m_press) begin
        m_mode = (m_mode + 1) % 4;
        m_hold = (m_mode == 1) ? DLY : 0;
      end else if (m_hold > 0) m_hold = m_hold - 1;
      m_press = fresh;
      void'(hist.pop_front());
      hist.push_back(btn);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive traffic and compare every cycle against the reference
  always @(negedge clk) begin
    ctl_tx = 1'($urandom); gps_tx = 1'($urandom); pc_tx = 1'($urandom);
    #1;
    if (rst_n && !done) begin
      bit e_c, e_g, e_p;
      string tag;
      e_c = 1; e_g = 1; e_p = 1;
      case (m_mode)
        0: begin tag = "R2"; e_c = pc_tx; e_p = ctl_tx; end
        1: begin
             if (m_hold > 0) tag = "R8";
             else begin tag = "R3"; e_p = gps_tx; e_g = pc_tx; end
           end
        2: begin tag = "R4"; e_c = gps_tx; e_g = ctl_tx; end
        default: begin tag = "R5"; e_c = gps_tx; e_p = ctl_tx; end
      endcase
      check(tag, "ctl_rx", ctl_rx, e_c);
      check(tag, "gps_rx", gps_rx, e_g);
      check(tag, "pc_rx",  pc_rx,  e_p);
      check("R6", "mode_led", mode_led, 1 << m_mode);
      check("R8", "hold_led", hold_led, (m_hold > 0) ? 1 : 0);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int len);
    @(negedge clk); btn = 1'b1; cycles(len);
    btn = 1'b0; cycles(DB + 6);
  endtask

  int hold_len;

  initial begin
    cycles(3);
    #2;
    check("R1", "reset mode_led", mode_led, 4'b0001);
    check("R1", "reset hold_led", hold_led, 0);
    rst_n = 1'b1;
    cycles(20);
    // R7: short glitches ignored
    @(negedge clk); btn = 1'b1; cycles(3); btn = 1'b0; cycles(20);
    check("R7", "glitch ignored", mode_led, 4'b0001);
    @(negedge clk); btn = 1'b1; cycles(DB - 1); btn = 1'b0; cycles(20);
    check("R7", "short level ignored", mode_led, 4'b0001);
    // R6: walk the ring
    press(DB + 5); cycles(DLY + 10);
    check("R3", "entered receiver-PC", mode_led, 4'b0010);
    press(DB + 5); cycles(20);
    check("R4", "entered controller-receiver", mode_led, 4'b0100);
    press(DB + 5); cycles(20);
    check("R5", "entered auto", mode_led, 4'b1000);
    press(DB + 5); cycles(10);
    check("R6", "wrap to mode 0", mode_led, 4'b0001);
    // R9: interrupt hold
    press(DB + 5);
    check("R9", "hold active", hold_led, 1);
    press(DB + 5);
    check("R9", "hold cancelled", hold_led, 0);
    check("R9", "left mode 1", mode_led, 4'b0100);
    press(DB + 5); press(DB + 5);
    check("R6", "back at mode 0", mode_led, 4'b0001);
    // R8: exact hold length on re-entry
    @(negedge clk); btn = 1'b1;
    hold_len = 0;
    for (int i = 0; i < 4 * DB; i++) begin
      @(negedge clk); #2;
      if (hold_led) break;
    end
    btn = 1'b0;
    while (hold_led && hold_len < 4 * DLY) begin
      hold_len++;
      @(negedge clk); #2;
    end
    check("R8", "hold length", hold_len, DLY);
    // R6: a long held press steps only once
    press(10 * DB);
    check("R6", "long press single step", mode_led, 4'b0100);
    press(DB + 5);
    cycles(30);
    check("R5", "auto with pc traffic", mode_led, 4'b1000);
    cycles(10);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule